// File: doc/BRIEF.md
# Eight-Line Prioritized Interrupt Controller

This block gathers eight interrupt request lines from peripherals and presents a single interrupt request to a processor. Each line is captured on its rising edge into a pending bit. Pending lines that are not masked compete on priority, and an in-service record keeps requests of equal or lower priority from interrupting a handler that is already running. When the processor acknowledges, the block registers an 8-bit vector for the winning line and moves that line from pending to in service. An end-of-interrupt strobe retires the most urgent in-service line.

Two priority schemes can be selected. In the nested scheme line 0 always ranks first and line 7 last. In the rotating scheme the line that was just retired ranks last and the line numbered after it ranks first. Software programs the line mask, the scheme and the upper five bits of the vector through a small write port.

Top module: `prio_intc`

## Requirements
- R1: After reset, `int_req_o` and `vec_valid_o` are low, `vec_o` is 0, no line is masked, the nested scheme is selected and the vector base is 0.
- R2: A line is latched as pending only on a 0-to-1 transition of its input. A level held high after it has been acknowledged does not latch it again.
- R3: `int_req_o` is high in the cycle after the clock edge that latches a forwardable request. It stays low whenever no unmasked line is pending.
- R4: Writing `cfg_sel_i`=0 loads the mask from `cfg_wdata_i`, where bit i set to 1 masks line i. A masked line never raises `int_req_o`, but it stays pending, and clearing its mask bit raises `int_req_o` on the next cycle.
- R5: In the nested scheme, line 0 has the highest priority and line 7 the lowest.
- R6: Writing `cfg_sel_i`=2 loads the vector base from `cfg_wdata_i[7:3]`. An accepted acknowledge (`int_ack_i` high while `int_req_o` is high) makes `vec_valid_o` high for exactly one cycle after that edge. In that cycle `vec_o` is {base, 3-bit line number}, and `vec_o` holds this value until the next accepted acknowledge.
- R7: An accepted acknowledge clears the winner's pending bit and marks the winner in service. `int_req_o` then drops unless a request of higher priority is pending.
- R8: A pending line is forwarded only if it ranks above every line in service. A line of higher rank than the current in-service line raises `int_req_o` again (nesting).
- R9: An `eoi_i` pulse clears only the highest-ranked in-service line. Lower-ranked in-service lines keep blocking.
- R10: Writing `cfg_sel_i`=1 with `cfg_wdata_i[0]`=1 selects rotating priority, and 0 selects nested priority. Either write makes line 0 the highest priority. In rotating mode, an end of interrupt on line k makes line k+1 (mod 8) the highest and line k the lowest.
- R11: An acknowledge while `int_req_o` is low is ignored. `vec_valid_o` stays low, `vec_o` is unchanged and no pending or in-service state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 8 | Interrupt request lines, rising edge latched |
| int_req_o | output | 1 | Interrupt request to the processor |
| int_ack_i | input | 1 | Interrupt acknowledge from the processor |
| eoi_i | input | 1 | End-of-interrupt strobe |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_sel_i | input | 2 | Configuration target: 0 mask, 1 scheme, 2 vector base |
| cfg_wdata_i | input | 8 | Configuration write data |
| vec_o | output | 8 | Registered vector of the last accepted acknowledge |
| vec_valid_o | output | 1 | One-cycle pulse marking a fresh vector |

## Verification
Every input edge, configuration write, acknowledge and end-of-interrupt is taken by one register stage. As a result, `int_req_o` reflects a new request, a mask change, a retired service or a rotation in the cycle directly after the edge that sampled the cause. The vector and its valid pulse appear one edge after the acknowledge. The bench changes inputs on the falling edge and reads outputs on the following falling edge, so each result is compared exactly one rising edge after its stimulus. The pulse is also checked to be gone one cycle later.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic {
    PRIO_NESTED = 1'b0,
    PRIO_ROTATE = 1'b1
  } prio_mode_e;

  typedef enum logic [1:0] {
    CFG_MASK = 2'd0,
    CFG_MODE = 2'd1,
    CFG_BASE = 2'd2
  } cfg_sel_e;

endpackage

// File: rtl/intc_edge_pend.sv
module intc_edge_pend #(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_i,
  input  logic [N_LINES-1:0] clr_i,
  output logic [N_LINES-1:0] pend_o
);

  logic [N_LINES-1:0] irq_q;
  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] pend_d;
  logic [N_LINES-1:0] rise;

  always_comb begin
    rise   = irq_i & ~irq_q;
    pend_d = (pend_q & ~clr_i) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= '0;
      pend_q <= '0;
    end else begin
      irq_q  <= irq_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/intc_rot_pick.sv
module intc_rot_pick #(
  parameter int N_LINES = 8,
  localparam int IW = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] vec_i,
  input  logic [IW-1:0]      ptr_i,
  output logic               found_o,
  output logic [IW-1:0]      idx_o,
  output logic [IW-1:0]      rank_o
);

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    rank_o  = '0;
    for (int r = N_LINES - 1; r >= 0; r--) begin
      logic [IW-1:0] ln;
      ln = ptr_i + IW'(r);
      if (vec_i[ln]) begin
        found_o = 1'b1;
        idx_o   = ln;
        rank_o  = IW'(r);
      end
    end
  end

endmodule

// File: rtl/intc_service.sv
module intc_service #(
  parameter int N_LINES = 8,
  localparam int IW = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rotate_i,
  input  logic               mode_wr_i,
  input  logic [N_LINES-1:0] set_i,
  input  logic               eoi_i,
  output logic [N_LINES-1:0] isr_o,
  output logic [IW-1:0]      eff_ptr_o,
  output logic               top_found_o,
  output logic [IW-1:0]      top_rank_o
);

  logic [N_LINES-1:0] isr_q;
  logic [N_LINES-1:0] isr_d;
  logic [IW-1:0]      ptr_q;
  logic [IW-1:0]      ptr_d;
  logic               ptr_en;
  logic [IW-1:0]      eff_ptr;
  logic               top_found;
  logic [IW-1:0]      top_idx;
  logic [IW-1:0]      top_rank;
  logic [N_LINES-1:0] eoi_clr;

  assign eff_ptr = rotate_i ? ptr_q : '0;

  intc_rot_pick #(.N_LINES(N_LINES)) i_top_pick (
    .vec_i   (isr_q),
    .ptr_i   (eff_ptr),
    .found_o (top_found),
    .idx_o   (top_idx),
    .rank_o  (top_rank)
  );

  always_comb begin
    eoi_clr = '0;
    if (eoi_i && top_found) begin
      eoi_clr[top_idx] = 1'b1;
    end
    isr_d  = (isr_q & ~eoi_clr) | set_i;
    ptr_en = mode_wr_i || (eoi_i && top_found && rotate_i);
    if (mode_wr_i) begin
      ptr_d = '0;
    end else begin
      ptr_d = top_idx + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
    end else begin
      isr_q <= isr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign isr_o       = isr_q;
  assign eff_ptr_o   = eff_ptr;
  assign top_found_o = top_found;
  assign top_rank_o  = top_rank;

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int VEC_W   = 8,
  localparam int IW     = $clog2(N_LINES),
  localparam int BASE_W = VEC_W - IW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_i,
  output logic               int_req_o,
  input  logic               int_ack_i,
  input  logic               eoi_i,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_sel_i,
  input  logic [VEC_W-1:0]   cfg_wdata_i,
  output logic [VEC_W-1:0]   vec_o,
  output logic               vec_valid_o
);

  logic [N_LINES-1:0] mask_q;
  prio_mode_e         mode_q;
  logic [BASE_W-1:0]  base_q;
  logic [VEC_W-1:0]   vec_q;
  logic               vld_q;

  logic               mask_we;
  logic               mode_we;
  logic               base_we;
  logic [N_LINES-1:0] pend;
  logic [N_LINES-1:0] cand;
  logic [N_LINES-1:0] ack_set;
  logic [N_LINES-1:0] isr;
  logic [IW-1:0]      eff_ptr;
  logic               top_found;
  logic [IW-1:0]      top_rank;
  logic               win_found;
  logic [IW-1:0]      win_idx;
  logic [IW-1:0]      win_rank;
  logic               forward;
  logic               ack_take;
  logic [VEC_W-1:0]   vec_d;

  always_comb begin
    mask_we = cfg_we_i && (cfg_sel_i == CFG_MASK);
    mode_we = cfg_we_i && (cfg_sel_i == CFG_MODE);
    base_we = cfg_we_i && (cfg_sel_i == CFG_BASE);
  end

  intc_edge_pend #(.N_LINES(N_LINES)) i_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_i  (irq_i),
    .clr_i  (ack_set),
    .pend_o (pend)
  );

  intc_service #(.N_LINES(N_LINES)) i_service (
    .clk         (clk),
    .rst_n       (rst_n),
    .rotate_i    (mode_q == PRIO_ROTATE),
    .mode_wr_i   (mode_we),
    .set_i       (ack_set),
    .eoi_i       (eoi_i),
    .isr_o       (isr),
    .eff_ptr_o   (eff_ptr),
    .top_found_o (top_found),
    .top_rank_o  (top_rank)
  );

  assign cand = pend & ~mask_q;

  intc_rot_pick #(.N_LINES(N_LINES)) i_win_pick (
    .vec_i   (cand),
    .ptr_i   (eff_ptr),
    .found_o (win_found),
    .idx_o   (win_idx),
    .rank_o  (win_rank)
  );

  always_comb begin
    forward  = win_found && (!top_found || (win_rank < top_rank));
    ack_take = int_ack_i && forward;
    ack_set  = '0;
    if (ack_take) begin
      ack_set[win_idx] = 1'b1;
    end
    vec_d = {base_q, win_idx};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= cfg_wdata_i[N_LINES-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PRIO_NESTED;
    end else if (mode_we) begin
      mode_q <= prio_mode_e'(cfg_wdata_i[0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_we) begin
      base_q <= cfg_wdata_i[VEC_W-1:IW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else if (ack_take) begin
      vec_q <= vec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= ack_take;
    end
  end

  assign int_req_o   = forward;
  assign vec_o       = vec_q;
  assign vec_valid_o = vld_q;

endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int N_LINES = 8,
  parameter int VEC_W   = 8,
  localparam int IW     = $clog2(N_LINES),
  localparam int BASE_W = VEC_W - IW
) (
  input logic               clk,
  input logic               rst_n,
  input logic               int_req_o,
  input logic               int_ack_i,
  input logic               eoi_i,
  input logic               vec_valid_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic [N_LINES-1:0] mask_q,
  input logic [N_LINES-1:0] pend_q,
  input logic [N_LINES-1:0] isr_q,
  input logic [BASE_W-1:0]  base_q
);

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~mask_q) == '0) |-> !int_req_o); // R3

  AST_ALL_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !int_req_o); // R4

  AST_VEC_CARRIES_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> (vec_o[VEC_W-1:IW] == $past(base_q))); // R6

  AST_WINNER_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> isr_q[vec_o[IW-1:0]]); // R7

  AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !(int_ack_i && int_req_o) && (isr_q != '0)) |=>
      ($countones(isr_q) == $countones($past(isr_q)) - 1)); // R9

  AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> $past(int_req_o && int_ack_i)); // R11

endmodule

bind prio_intc intc_checker #(.N_LINES(N_LINES), .VEC_W(VEC_W)) i_intc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .int_req_o   (int_req_o),
  .int_ack_i   (int_ack_i),
  .eoi_i       (eoi_i),
  .vec_valid_o (vec_valid_o),
  .vec_o       (vec_o),
  .mask_q      (mask_q),
  .pend_q      (pend),
  .isr_q       (isr),
  .base_q      (base_q)
);

// File: tb/test_prio_intc.sv
module test_prio_intc;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic [7:0] irq;
  logic       int_req;
  logic       int_ack;
  logic       eoi;
  logic       cfg_we;
  logic [1:0] cfg_sel;
  logic [7:0] cfg_wdata;
  logic [7:0] vec;
  logic       vec_valid;

  int n_checks = 0;
  int n_fails  = 0;

  prio_intc i_prio_intc (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_i       (irq),
    .int_req_o   (int_req),
    .int_ack_i   (int_ack),
    .eoi_i       (eoi),
    .cfg_we_i    (cfg_we),
    .cfg_sel_i   (cfg_sel),
    .cfg_wdata_i (cfg_wdata),
    .vec_o       (vec),
    .vec_valid_o (vec_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic do_ack(input string req, input logic [7:0] exp_vec);
    int_ack = 1'b1;
    step();
    int_ack = 1'b0;
    chk({req, " valid"}, vec_valid, 1);
    chk({req, " vector"}, vec, exp_vec);
    step();
    chk({req, " valid pulse ends"}, vec_valid, 0);
  endtask

  task automatic do_eoi();
    eoi = 1'b1;
    step();
    eoi = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 int_req", int_req, 0);
    chk("R1 vec_valid", vec_valid, 0);
    chk("R1 vec", vec, 0);
  endtask

  task automatic t_nested();
    cfg_write(2'd2, 8'hA8);
    irq[5] = 1'b1; irq[2] = 1'b1;
    step();
    chk("R3 int_req after edge", int_req, 1);
    do_ack("R5 R6 line2 wins", 8'hAA);
    chk("R8 line5 blocked by line2", int_req, 0);
    do_eoi();
    chk("R9 line5 forwarded after eoi", int_req, 1);
    do_ack("R7 line5 vector", 8'hAD);
    chk("R7 int_req drops", int_req, 0);
    do_eoi();
    step();
    chk("R2 held level not relatched", int_req, 0);
    irq = '0;
    step();
  endtask

  task automatic t_preempt();
    irq[4] = 1'b1;
    step();
    do_ack("R5 line4", 8'hAC);
    irq[1] = 1'b1;
    step();
    chk("R8 higher line nests", int_req, 1);
    do_ack("R8 line1 vector", 8'hA9);
    do_eoi();
    irq[5] = 1'b1;
    step();
    chk("R9 line4 still in service blocks line5", int_req, 0);
    do_eoi();
    chk("R9 line5 released", int_req, 1);
    do_ack("R6 line5 vector", 8'hAD);
    do_eoi();
    irq = '0;
    step();
  endtask

  task automatic t_mask();
    cfg_write(2'd0, 8'h08);
    irq[3] = 1'b1;
    step();
    chk("R4 masked line silent", int_req, 0);
    step();
    chk("R4 masked line still silent", int_req, 0);
    cfg_write(2'd0, 8'h00);
    chk("R4 unmask raises int_req", int_req, 1);
    do_ack("R4 line3 vector", 8'hAB);
    do_eoi();
    irq = '0;
    step();
  endtask

  task automatic t_rotate();
    cfg_write(2'd1, 8'h01);
    irq[2] = 1'b1; irq[6] = 1'b1;
    step();
    do_ack("R10 line2 first", 8'hAA);
    chk("R8 rotate line6 blocked", int_req, 0);
    do_eoi();
    irq = '0;
    chk("R10 line6 forwarded", int_req, 1);
    irq[1] = 1'b1;
    step();
    do_ack("R10 line6 outranks line1", 8'hAE);
    do_eoi();
    do_ack("R10 line1 next", 8'hA9);
    do_eoi();
    irq = '0;
    step();
    irq[0] = 1'b1; irq[1] = 1'b1;
    step();
    do_ack("R10 line0 outranks retired line1", 8'hA8);
    do_eoi();
    do_ack("R10 line1 last", 8'hA9);
    do_eoi();
    irq = '0;
    cfg_write(2'd1, 8'h00);
    irq[7] = 1'b1; irq[6] = 1'b1;
    step();
    do_ack("R10 nested again line6", 8'hAE);
    do_eoi();
    do_ack("R10 nested again line7", 8'hAF);
    do_eoi();
    irq = '0;
    step();
  endtask

  task automatic t_spurious();
    chk("R11 idle", int_req, 0);
    int_ack = 1'b1;
    step();
    int_ack = 1'b0;
    chk("R11 no valid", vec_valid, 0);
    chk("R11 vec unchanged", vec, 8'hAF);
    irq[3] = 1'b1;
    step();
    chk("R11 state intact", int_req, 1);
    do_ack("R11 line3 after spurious", 8'hAB);
    do_eoi();
    irq = '0;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq = '0; int_ack = 1'b0; eoi = 1'b0;
    cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    step(); step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_nested();
    t_preempt();
    t_mask();
    t_rotate();
    t_spurious();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule